// File: doc/BRIEF.md
# Programmable 5-bit PWM generator

This block produces a pulse-width modulated square wave whose period is split into 32 equal slots. A 5-bit duty setting decides how many of those slots drive the output high, so the register alone spans 0/32 through 31/32. A separate command forces the output permanently high, and another command parks the block in a low-power state with the output held low. The PWM frequency is fixed per build: a prescaler divides the system clock down to 32 slot ticks per PWM period, for a PWM rate of 1, 5, 10 or 25 kHz.

A host drives the block through a parallel write port that carries one decoded command byte and one data byte per strobe. The serial bus front end is outside this block. The current setting, including the mode flags, is always visible on a readback byte. After reset the block runs at half scale with no host access, so it can serve as a free-running oscillator.

Top module: `pwm5_gen`

## Requirements
- R1: After reset the duty setting is 16 (binary 10000), full-on and shutdown are clear, and the readback byte reads 8'h10.
- R2: With duty setting N (neither mode flag set), the output is high for exactly N*DIV system clocks of every 32*DIV clock period, where DIV = CLK_HZ/(32*PWM_HZ).
- R3: A duty setting of 0 gives a constantly low output; 31 gives 31 of 32 slots high.
- R4: A duty write (command 8'h01) shows on the readback byte from the next clock, but the output switches to the new duty only at the start of the next PWM period.
- R5: Command 8'h02 sets full-on mode, which drives the output continuously high; readback bit 6 reads 1.
- R6: A duty write (command 8'h01) clears full-on mode.
- R7: Command 8'h03 enters shutdown: the output is held low (over full-on too), the slot counter freezes at slot 0, and readback bit 7 reads 1. Command 8'h04 leaves shutdown and the period restarts from slot 0, so the output is high for the first N*DIV clocks.
- R8: Command codes other than 8'h01 to 8'h04 change nothing, and bits 7:5 of the data byte are ignored on a duty write.
- R9: The readback byte is {shutdown, full-on, 1'b0, duty[4:0]}, with duty writes accepted during shutdown.
- R10: The PWM period is CLK_HZ/PWM_HZ clocks; PWM_HZ must be 1000, 5000, 10000 or 25000 and CLK_HZ a nonzero multiple of 32*PWM_HZ, or elaboration stops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Strobe: command and data bytes valid this cycle |
| cmdByte | input | 8 | Decoded command code |
| dataByte | input | 8 | Data byte accompanying the command |
| rdData | output | 8 | Readback of shutdown, full-on and duty setting |
| pwmOut | output | 1 | Modulated output |

## Verification
The duty register is swept over half scale, a quarter, a small value with junk in its upper data bits, and both ends (0 and 31), which separates a slot comparison that is off by one from a correct one and shows whether the extreme values saturate. Full-on is entered and then cancelled by a duty write, which tells a sticky flag from a correctly cleared one. Shutdown is entered on top of full-on, written to while asleep and left again, with the high time right after wake counted to show that the period restarts at slot 0 instead of resuming. A clock-by-clock model checks every cycle, so a duty change that lands mid-period shows as a mismatch.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;
  localparam int DUTY_W = 5;
  localparam int SLOTS  = 1 << DUTY_W;
  localparam logic [DUTY_W-1:0] DUTY_RESET = 5'b10000;

  typedef enum logic [7:0] {
    CMD_DUTY  = 8'h01,
    CMD_FULL  = 8'h02,
    CMD_SLEEP = 8'h03,
    CMD_WAKE  = 8'h04
  } cmdCode_e;

  typedef struct packed {
    logic              loadDuty;
    logic              setFull;
    logic              enterSleep;
    logic              leaveSleep;
    logic [DUTY_W-1:0] dutyVal;
  } ctrlStrobe_t;
endpackage

// File: rtl/pwm5_ctrl.sv
module pwm5_ctrl
  import pwm5_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [7:0]  cmdByte,
  input  logic [7:0]  dataByte,
  output ctrlStrobe_t strobe,
  output logic        fullOn,
  output logic        sleeping
);
  logic unusedDataBits;
  assign unusedDataBits = ^dataByte[7:DUTY_W];

  always_comb begin
    strobe = '0;
    strobe.dutyVal = dataByte[DUTY_W-1:0];
    if (wrEn) begin
      case (cmdCode_e'(cmdByte))
        CMD_DUTY:  strobe.loadDuty   = 1'b1;
        CMD_FULL:  strobe.setFull    = 1'b1;
        CMD_SLEEP: strobe.enterSleep = 1'b1;
        CMD_WAKE:  strobe.leaveSleep = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fullOn   <= 1'b0;
      sleeping <= 1'b0;
    end else begin
      if (strobe.loadDuty)   fullOn   <= 1'b0;
      if (strobe.setFull)    fullOn   <= 1'b1;
      if (strobe.enterSleep) sleeping <= 1'b1;
      if (strobe.leaveSleep) sleeping <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm5_datapath.sv
module pwm5_datapath
  import pwm5_pkg::*;
#(
  parameter int DIV   = 4,
  parameter int PRE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic              fullOn,
  input  logic              sleeping,
  output logic [DUTY_W-1:0] dutyReg,
  output logic [DUTY_W-1:0] activeDuty,
  output logic [DUTY_W-1:0] slot,
  output logic              pwmOut
);
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(DIV - 1);
  localparam logic [DUTY_W-1:0] SLOT_LAST = DUTY_W'(SLOTS - 1);

  logic             tick;
  logic             periodEnd;

  generate
    if (DIV == 1) begin : g_noPrescale
      assign tick = 1'b1;
    end else begin : g_prescale
      logic [PRE_W-1:0] pre;
      assign tick = (pre == PRE_LAST);
      always_ff @(posedge clk) begin
        if (rst || sleeping || tick) pre <= '0;
        else                         pre <= pre + 1'b1;
      end
    end
  endgenerate

  assign periodEnd = tick && (slot == SLOT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      dutyReg    <= DUTY_RESET;
      activeDuty <= DUTY_RESET;
      slot       <= '0;
    end else begin
      if (strobe.loadDuty) dutyReg <= strobe.dutyVal;
      if (sleeping) begin
        slot       <= '0;
        activeDuty <= dutyReg;
      end else begin
        if (tick)      slot       <= slot + 1'b1;
        if (periodEnd) activeDuty <= dutyReg;
      end
    end
  end

  assign pwmOut = !sleeping && (fullOn || (slot < activeDuty));
endmodule

// File: rtl/pwm5_gen.sv
module pwm5_gen
  import pwm5_pkg::*;
#(
  parameter int CLK_HZ = 3_200_000,
  parameter int PWM_HZ = 25_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic [7:0] cmdByte,
  input  logic [7:0] dataByte,
  output logic [7:0] rdData,
  output logic       pwmOut
);
  localparam int SLOT_HZ = PWM_HZ * SLOTS;
  localparam int DIV     = (SLOT_HZ > 0) ? CLK_HZ / SLOT_HZ : 0;
  localparam int PRE_W   = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (!(PWM_HZ == 1000 || PWM_HZ == 5000 || PWM_HZ == 10000 || PWM_HZ == 25000)) begin : g_badRate
      $error("pwm5_gen: PWM_HZ must be 1000, 5000, 10000 or 25000");
    end
    if (DIV < 1 || (CLK_HZ % SLOT_HZ) != 0) begin : g_badDiv
      $error("pwm5_gen: CLK_HZ must be a nonzero multiple of 32*PWM_HZ");
    end
  endgenerate

  ctrlStrobe_t       strobe;
  logic              fullOn;
  logic              sleeping;
  logic [DUTY_W-1:0] dutyReg;
  logic [DUTY_W-1:0] activeDuty;
  logic [DUTY_W-1:0] slot;

  pwm5_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .cmdByte  (cmdByte),
    .dataByte (dataByte),
    .strobe   (strobe),
    .fullOn   (fullOn),
    .sleeping (sleeping)
  );

  pwm5_datapath #(.DIV(DIV), .PRE_W(PRE_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .fullOn     (fullOn),
    .sleeping   (sleeping),
    .dutyReg    (dutyReg),
    .activeDuty (activeDuty),
    .slot       (slot),
    .pwmOut     (pwmOut)
  );

  assign rdData = {sleeping, fullOn, 1'b0, dutyReg};
endmodule

// File: rtl/pwm5_gen_chk.sv
module pwm5_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       wrEn,
  input logic [7:0] cmdByte,
  input logic [7:0] dataByte,
  input logic [7:0] rdData,
  input logic       pwmOut,
  input logic [4:0] activeDuty,
  input logic [4:0] slot
);
  p_reset_half_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rdData == 8'h10));

  p_zero_low_r3: assert property (@(posedge clk) disable iff (rst)
    (activeDuty == 5'd0 && !rdData[6]) |-> !pwmOut);

  p_duty_visible_r4: assert property (@(posedge clk) disable iff (rst)
    (wrEn && cmdByte == 8'h01) |=> (rdData[4:0] == $past(dataByte[4:0])));

  p_full_high_r5: assert property (@(posedge clk) disable iff (rst)
    (rdData[6] && !rdData[7]) |-> pwmOut);

  p_full_cleared_r6: assert property (@(posedge clk) disable iff (rst)
    (wrEn && cmdByte == 8'h01) |=> !rdData[6]);

  p_sleep_low_r7: assert property (@(posedge clk) disable iff (rst)
    rdData[7] |-> !pwmOut);

  p_sleep_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (rdData[7] && $past(rdData[7])) |-> (slot == 5'd0));

  p_junk_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (cmdByte == 8'h00 || cmdByte > 8'h04)) |=> $stable(rdData));
endmodule

bind pwm5_gen pwm5_gen_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .wrEn       (wrEn),
  .cmdByte    (cmdByte),
  .dataByte   (dataByte),
  .rdData     (rdData),
  .pwmOut     (pwmOut),
  .activeDuty (activeDuty),
  .slot       (slot)
);

// File: tb/pwm5_gen_test.sv
module pwm5_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 3_200_000;
  localparam int PWM_HZ = 25_000;
  localparam int DIV    = CLK_HZ / (PWM_HZ * 32);
  localparam int PERIOD = CLK_HZ / PWM_HZ;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic [7:0] dataByte = 8'h00;
  logic [7:0] rdData;
  logic       pwmOut;

  int    compared = 0;
  int    mismatched = 0;
  int    cycles = 0;
  string curReq = "R1";

  int mDuty = 16, mActive = 16, mPre = 0, mSlot = 0, mFull = 0, mSleep = 0;

  pwm5_gen #(.CLK_HZ(CLK_HZ), .PWM_HZ(PWM_HZ)) uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .cmdByte(cmdByte),
    .dataByte(dataByte), .rdData(rdData), .pwmOut(pwmOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: state after each rising edge.
  always @(posedge clk) begin
    if (rst) begin
      mDuty = 16; mActive = 16; mPre = 0; mSlot = 0; mFull = 0; mSleep = 0;
    end else begin
      int nDuty, nFull, nSleep;
      nDuty = mDuty; nFull = mFull; nSleep = mSleep;
      if (wrEn) begin
        case (cmdByte)
          8'h01: begin nDuty = dataByte % 32; nFull = 0; end
          8'h02: nFull = 1;
          8'h03: nSleep = 1;
          8'h04: nSleep = 0;
          default: ;
        endcase
      end
      if (mSleep != 0) begin
        mPre = 0; mSlot = 0; mActive = mDuty;
      end else if (mPre == DIV - 1) begin
        if (mSlot == 31) mActive = mDuty;
        mPre = 0;
        mSlot = (mSlot + 1) % 32;
      end else begin
        mPre = mPre + 1;
      end
      mDuty = nDuty; mFull = nFull; mSleep = nSleep;
    end
  end

  // Clock-by-clock comparison against the model.
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      logic expOut;
      logic [7:0] expRd;
      expOut = (mSleep == 0) && ((mFull != 0) || (mSlot < mActive));
      expRd  = 8'((mSleep << 7) | (mFull << 6) | mDuty);
      compared++;
      if (pwmOut !== expOut || rdData !== expRd) begin
        mismatched++;
        $display("FAIL %s: model compare pwmOut=%0b rdData=%02h expected pwmOut=%0b rdData=%02h",
                 curReq, pwmOut, rdData, expOut, expRd);
      end
    end
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic wr(input logic [7:0] c, input logic [7:0] d);
    wrEn = 1'b1; cmdByte = c; dataByte = d;
    @(negedge clk);
    wrEn = 1'b0; cmdByte = 8'h00; dataByte = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measureHigh(input string req, input int expHigh);
    int hi = 0;
    idle(2 * PERIOD);
    for (int i = 0; i < PERIOD; i++) begin
      if (pwmOut) hi++;
      @(negedge clk);
    end
    check(req, hi, expHigh);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    // R1: reset state
    curReq = "R1";
    check("R1 readback", int'(rdData), 8'h10);
    measureHigh("R1 half scale", 16 * DIV);

    // R4 / R2: duty change at period boundary
    curReq = "R4";
    wr(8'h01, 8'h08);
    check("R4 readback now", int'(rdData), 8'h08);
    curReq = "R2";
    measureHigh("R2 quarter", 8 * DIV);

    // R8: upper data bits ignored
    curReq = "R8";
    wr(8'h01, 8'hE5);
    check("R8 upper bits", int'(rdData), 8'h05);
    measureHigh("R2 duty 5", 5 * DIV);

    // R3: extremes
    curReq = "R3";
    wr(8'h01, 8'h00);
    measureHigh("R3 zero", 0);
    wr(8'h01, 8'h1F);
    measureHigh("R3 max", 31 * DIV);

    // R5: full-on
    curReq = "R5";
    wr(8'h02, 8'h00);
    check("R5 readback", int'(rdData), 8'h5F);
    measureHigh("R5 full on", PERIOD);

    // R6: duty write clears full-on
    curReq = "R6";
    wr(8'h01, 8'h03);
    check("R6 cleared", int'(rdData), 8'h03);
    measureHigh("R6 duty 3", 3 * DIV);

    // R8: unknown commands
    curReq = "R8";
    wr(8'h7A, 8'h11);
    wr(8'h00, 8'h1F);
    wr(8'h05, 8'h1F);
    check("R8 ignored", int'(rdData), 8'h03);
    measureHigh("R8 output kept", 3 * DIV);

    // R7 / R9: shutdown
    curReq = "R7";
    wr(8'h02, 8'h00);
    wr(8'h03, 8'h00);
    check("R7 readback", int'(rdData), 8'hC3);
    measureHigh("R7 low over full-on", 0);
    curReq = "R9";
    wr(8'h01, 8'h09);
    check("R9 write while asleep", int'(rdData), 8'h89);
    curReq = "R7";
    idle(7);
    wr(8'h04, 8'h00);
    begin
      int hi = 0;
      for (int i = 0; i < 9 * DIV; i++) begin
        if (pwmOut) hi++;
        @(negedge clk);
      end
      check("R7 restart high run", hi, 9 * DIV);
      check("R7 low after run", int'(pwmOut), 0);
    end

    // R10: period length
    curReq = "R10";
    wr(8'h01, 8'h10);
    idle(2 * PERIOD);
    while (!(pwmOut && cycles > 0)) @(negedge clk);
    while (pwmOut) @(negedge clk);
    while (!pwmOut) @(negedge clk);
    begin
      int len = 0;
      do begin @(negedge clk); len++; end while (pwmOut);
      while (!pwmOut) begin @(negedge clk); len++; end
      check("R10 period", len, PERIOD);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule